// File: doc/BRIEF.md
# Page Write Buffer with Timed Commit

This block gathers the data bytes of one pending write for a 1024-byte nonvolatile array. It then copies them into the array during a self-timed programming window of fixed length. A session opens with a start strobe that carries a 10-bit address. Each byte strobe stores one byte at the current position inside the addressed 16-byte page, and the position then advances. A deselect event closes the session. If the deselect lands exactly on a byte boundary and at least one byte was loaded, the programming window starts. Otherwise the pending data is thrown away.

During the window the block steps through the page positions one per cycle. It presents each address on a probe output, and a neighbouring protection decoder answers with a permit bit. Only positions that were loaded and are permitted get written. The busy flag stays high for the whole window. A one-cycle completion pulse marks its last cycle, and a neighbour uses that pulse to clear its write-enable latch. A registered read port serves array reads when the block is idle and refuses them while busy. Once started, the window ignores every other input until it ends.

Top module: `page_commit_buffer`

## Requirements
- R1: After reset, busy_o, done_o, rd_valid_o and rd_refused_o are 0, and every array byte reads back as 0x00.
- R2: A deselect with desel_whole_i=1, after at least one loaded byte, raises busy_o from the next cycle on for exactly PROG_CYCLES cycles (default 40). After that, each loaded byte reads back at its address.
- R3: The write position is start address bits [3:0] and advances by one per loaded byte. Bits [9:4] never change, so position 15 is followed by position 0 of the same page. A later byte at a position replaces the earlier one.
- R4: Page positions that received no byte keep their previous array contents after programming.
- R5: A deselect with desel_whole_i=0 discards the session: busy_o stays 0 and the array is unchanged.
- R6: A deselect with desel_whole_i=1 but no byte loaded starts no programming.
- R7: During the window, chk_addr_o shows {page, position} for each position in turn. A loaded position whose chk_ok_i is 0 is not written and keeps its old contents.
- R8: A read request that is sampled while busy_o=1 gives rd_refused_o=1 and rd_valid_o=0 one cycle later. A request sampled while busy_o=0 gives rd_valid_o=1 one cycle later, with rd_data_o holding the byte at rd_addr_i.
- R9: done_o is high for exactly one cycle per window, in its last busy cycle.
- R10: While busy_o=1, start, load and deselect strobes are ignored. The window runs to its full length, and no data from those strobes reaches the array.
- R11: A load and a whole-byte deselect in the same cycle store the byte first. The deselect is then judged with that byte counted, so a session whose only byte arrives in that cycle still commits it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Opens a new session |
| start_addr_i | input | ADDR_W | Start address for the session |
| load_i | input | 1 | Byte strobe |
| load_data_i | input | DATA_W | Byte to store at the current position |
| desel_i | input | 1 | Deselect event that closes the session |
| desel_whole_i | input | 1 | Deselect fell on a byte boundary |
| chk_addr_o | output | ADDR_W | Address being probed for permission during programming |
| chk_ok_i | input | 1 | Permit answer for chk_addr_o |
| busy_o | output | 1 | Programming window active |
| done_o | output | 1 | Last cycle of the programming window |
| rd_req_i | input | 1 | Array read request |
| rd_addr_i | input | ADDR_W | Array read address |
| rd_data_o | output | DATA_W | Read data, valid with rd_valid_o |
| rd_valid_o | output | 1 | Read served |
| rd_refused_o | output | 1 | Read refused because programming was active |

## Verification
The end of a programming window and a read request can fall in the same cycle. That cycle is exactly where a read could slip past the busy guard. The bench watches for the completion pulse and raises a read request in that very cycle; it expects a refusal one cycle later. It then holds the request for one more cycle and expects it to be served with the newly programmed byte. A load and a whole-byte deselect are also driven together. The bench judges the result by whether the window opens and the byte lands, compared against a bench-side page model that also produces the random sessions.

// File: rtl/pcb_pkg.sv
package pcb_pkg;

    localparam int unsigned ADDR_W_DEF      = 10;
    localparam int unsigned DATA_W_DEF      = 8;
    localparam int unsigned POS_W_DEF       = 4;
    localparam int unsigned PROG_CYCLES_DEF = 40;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_FILL = 2'd1,
        PH_PROG = 2'd2
    } phase_e;

    typedef struct packed {
        logic valid;
        logic refused;
    } rd_flag_t;

    function automatic logic commit_allowed(input logic whole, input logic has_data);
        return whole && has_data;
    endfunction

endpackage

// File: rtl/pcb_seq.sv
module pcb_seq
    import pcb_pkg::*;
#(
    parameter int unsigned PROG_CYCLES = PROG_CYCLES_DEF,
    parameter int unsigned CNT_W       = $clog2(PROG_CYCLES + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic             load_i,
    input  logic             desel_i,
    input  logic             whole_i,
    input  logic             has_data_i,
    output logic             open_o,
    output logic             take_o,
    output logic             clr_o,
    output logic             busy_o,
    output logic             done_o,
    output logic [CNT_W-1:0] cnt_o
);

    localparam logic [CNT_W-1:0] LAST = CNT_W'(PROG_CYCLES - 1);

    phase_e           phase_q, phase_d;
    logic [CNT_W-1:0] cnt_q;
    logic             commit, discard, filling, prog;

    assign prog    = (phase_q == PH_PROG);
    assign filling = (phase_q == PH_FILL);

    // a deselect outranks a start seen in the same cycle
    assign open_o  = start_i && !prog && !desel_i;
    assign take_o  = load_i && filling && !start_i;
    assign commit  = desel_i && filling && commit_allowed(whole_i, has_data_i);
    assign discard = desel_i && filling && !commit;
    assign done_o  = prog && (cnt_q == LAST);
    assign clr_o   = discard || done_o;
    assign busy_o  = prog;
    assign cnt_o   = cnt_q;

    always_comb begin
        phase_d = phase_q;
        unique case (phase_q)
            PH_IDLE: if (open_o) phase_d = PH_FILL;
            PH_FILL: begin
                if (commit)       phase_d = PH_PROG;
                else if (discard) phase_d = PH_IDLE;
            end
            PH_PROG: if (done_o) phase_d = PH_IDLE;
            default: phase_d = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            cnt_q   <= '0;
        end else begin
            phase_q <= phase_d;
            if (commit)    cnt_q <= '0;
            else if (prog) cnt_q <= done_o ? '0 : cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/pcb_loader.sv
module pcb_loader
    import pcb_pkg::*;
#(
    parameter int unsigned ADDR_W = ADDR_W_DEF,
    parameter int unsigned DATA_W = DATA_W_DEF,
    parameter int unsigned POS_W  = POS_W_DEF,
    parameter int unsigned PAGE_BYTES = 1 << POS_W,
    parameter int unsigned BASE_W     = ADDR_W - POS_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              open_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              take_i,
    input  logic [DATA_W-1:0] data_i,
    input  logic              clr_i,
    input  logic [POS_W-1:0]  sel_i,
    output logic [BASE_W-1:0] base_o,
    output logic [DATA_W-1:0] sel_byte_o,
    output logic              sel_loaded_o,
    output logic              has_data_o
);

    logic [BASE_W-1:0]     base_q;
    logic [POS_W-1:0]      ptr_q;
    logic [PAGE_BYTES-1:0] mask_w;
    logic [DATA_W-1:0]     slot_w [PAGE_BYTES];

    for (genvar p = 0; p < PAGE_BYTES; p++) begin : g_slot
        logic              v_q;
        logic [DATA_W-1:0] b_q;
        logic              hit;

        assign hit = take_i && (ptr_q == POS_W'(p));

        always_ff @(posedge clk) begin
            if (rst) begin
                v_q <= 1'b0;
                b_q <= '0;
            end else if (clr_i || open_i) begin
                v_q <= 1'b0;
            end else if (hit) begin
                v_q <= 1'b1;
                b_q <= data_i;
            end
        end

        assign mask_w[p] = v_q;
        assign slot_w[p] = b_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q <= '0;
            ptr_q  <= '0;
        end else if (open_i) begin
            base_q <= addr_i[ADDR_W-1:POS_W];
            ptr_q  <= addr_i[POS_W-1:0];
        end else if (take_i) begin
            ptr_q  <= ptr_q + 1'b1;
        end
    end

    assign base_o       = base_q;
    assign sel_byte_o   = slot_w[sel_i];
    assign sel_loaded_o = mask_w[sel_i];
    assign has_data_o   = (|mask_w) || take_i;

endmodule

// File: rtl/pcb_array.sv
module pcb_array
    import pcb_pkg::*;
#(
    parameter int unsigned ADDR_W = ADDR_W_DEF,
    parameter int unsigned DATA_W = DATA_W_DEF,
    parameter int unsigned DEPTH  = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] waddr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              re_i,
    input  logic [ADDR_W-1:0] raddr_i,
    output logic [DATA_W-1:0] rdata_o
);

    logic [DATA_W-1:0] cell_q [DEPTH];
    logic [DATA_W-1:0] rdata_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) cell_q[i] <= '0;
        end else if (we_i) begin
            cell_q[waddr_i] <= wdata_i;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)       rdata_q <= '0;
        else if (re_i) rdata_q <= cell_q[raddr_i];
    end

    assign rdata_o = rdata_q;

endmodule

// File: rtl/page_commit_buffer.sv
module page_commit_buffer
    import pcb_pkg::*;
#(
    parameter int unsigned ADDR_W      = ADDR_W_DEF,
    parameter int unsigned DATA_W      = DATA_W_DEF,
    parameter int unsigned POS_W       = POS_W_DEF,
    parameter int unsigned PROG_CYCLES = PROG_CYCLES_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] start_addr_i,
    input  logic              load_i,
    input  logic [DATA_W-1:0] load_data_i,
    input  logic              desel_i,
    input  logic              desel_whole_i,
    output logic [ADDR_W-1:0] chk_addr_o,
    input  logic              chk_ok_i,
    output logic              busy_o,
    output logic              done_o,
    input  logic              rd_req_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    output logic [DATA_W-1:0] rd_data_o,
    output logic              rd_valid_o,
    output logic              rd_refused_o
);

    localparam int unsigned PAGE_BYTES = 1 << POS_W;
    localparam int unsigned BASE_W     = ADDR_W - POS_W;
    localparam int unsigned CNT_W      = $clog2(PROG_CYCLES + 1);

    logic              open, take, clr, busy, done;
    logic [CNT_W-1:0]  cnt;
    logic              has_data, sel_loaded, copying, wr_en;
    logic [BASE_W-1:0] base;
    logic [DATA_W-1:0] sel_byte;
    logic [POS_W-1:0]  pos;
    rd_flag_t          rflag_q;

    pcb_seq #(
        .PROG_CYCLES(PROG_CYCLES),
        .CNT_W      (CNT_W)
    ) u_seq (
        .clk       (clk),
        .rst       (rst),
        .start_i   (start_i),
        .load_i    (load_i),
        .desel_i   (desel_i),
        .whole_i   (desel_whole_i),
        .has_data_i(has_data),
        .open_o    (open),
        .take_o    (take),
        .clr_o     (clr),
        .busy_o    (busy),
        .done_o    (done),
        .cnt_o     (cnt)
    );

    assign pos     = cnt[POS_W-1:0];
    assign copying = busy && (cnt < CNT_W'(PAGE_BYTES));

    pcb_loader #(
        .ADDR_W(ADDR_W),
        .DATA_W(DATA_W),
        .POS_W (POS_W)
    ) u_loader (
        .clk         (clk),
        .rst         (rst),
        .open_i      (open),
        .addr_i      (start_addr_i),
        .take_i      (take),
        .data_i      (load_data_i),
        .clr_i       (clr),
        .sel_i       (pos),
        .base_o      (base),
        .sel_byte_o  (sel_byte),
        .sel_loaded_o(sel_loaded),
        .has_data_o  (has_data)
    );

    assign chk_addr_o = {base, pos};
    assign wr_en      = copying && sel_loaded && chk_ok_i;

    pcb_array #(
        .ADDR_W(ADDR_W),
        .DATA_W(DATA_W)
    ) u_array (
        .clk    (clk),
        .rst    (rst),
        .we_i   (wr_en),
        .waddr_i(chk_addr_o),
        .wdata_i(sel_byte),
        .re_i   (rd_req_i && !busy),
        .raddr_i(rd_addr_i),
        .rdata_o(rd_data_o)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rflag_q <= '0;
        end else begin
            rflag_q.valid   <= rd_req_i && !busy;
            rflag_q.refused <= rd_req_i && busy;
        end
    end

    assign busy_o       = busy;
    assign done_o       = done;
    assign rd_valid_o   = rflag_q.valid;
    assign rd_refused_o = rflag_q.refused;

endmodule

// File: rtl/pcb_checker.sv
module pcb_checker #(
    parameter int unsigned ADDR_W      = 10,
    parameter int unsigned POS_W       = 4,
    parameter int unsigned PROG_CYCLES = 40
) (
    input logic              clk,
    input logic              rst,
    input logic              desel_i,
    input logic              desel_whole_i,
    input logic [ADDR_W-1:0] chk_addr_o,
    input logic              busy_o,
    input logic              done_o,
    input logic              rd_req_i,
    input logic              rd_valid_o,
    input logic              rd_refused_o
);

    int unsigned run_q;

    always_ff @(posedge clk) begin
        if (rst)         run_q <= 0;
        else if (busy_o) run_q <= run_q + 1;
        else             run_q <= 0;
    end

    p_busy_len_r2: assert property (@(posedge clk) disable iff (rst)
        $fell(busy_o) |-> (run_q == PROG_CYCLES));

    p_busy_cause_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(busy_o) |-> $past(desel_i && desel_whole_i));

    p_done_inside_r9: assert property (@(posedge clk) disable iff (rst)
        done_o |-> busy_o);

    p_done_last_r9: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !busy_o);

    p_refuse_r8: assert property (@(posedge clk) disable iff (rst)
        (rd_req_i && busy_o) |=> (rd_refused_o && !rd_valid_o));

    p_serve_r8: assert property (@(posedge clk) disable iff (rst)
        (rd_req_i && !busy_o) |=> (rd_valid_o && !rd_refused_o));

    p_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (busy_o && !done_o) |=> busy_o);

    p_page_fixed_r3: assert property (@(posedge clk) disable iff (rst)
        (busy_o && $past(busy_o)) |->
            (chk_addr_o[ADDR_W-1:POS_W] == $past(chk_addr_o[ADDR_W-1:POS_W])));

endmodule

bind page_commit_buffer pcb_checker #(
    .ADDR_W     (ADDR_W),
    .POS_W      (POS_W),
    .PROG_CYCLES(PROG_CYCLES)
) u_chk (
    .clk          (clk),
    .rst          (rst),
    .desel_i      (desel_i),
    .desel_whole_i(desel_whole_i),
    .chk_addr_o   (chk_addr_o),
    .busy_o       (busy_o),
    .done_o       (done_o),
    .rd_req_i     (rd_req_i),
    .rd_valid_o   (rd_valid_o),
    .rd_refused_o (rd_refused_o)
);

// File: tb/page_commit_buffer_bench.sv
module page_commit_buffer_bench;

    localparam int PROG = 40;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start = 1'b0, load = 1'b0, desel = 1'b0, whole = 1'b0, rd_req = 1'b0;
    logic [9:0] start_addr = '0, rd_addr = '0, chk_addr;
    logic [7:0] load_data = '0, rd_data;
    logic       chk_ok, busy, done, rd_valid, rd_refused;
    logic [10:0] perm_hi = 11'h400;

    int total = 0;
    int fails = 0;

    logic [7:0] ref_mem [1024];
    logic [7:0] s_buf [16];
    bit   [15:0] s_mask;
    bit   [5:0]  s_base;
    bit   [3:0]  s_ptr;
    bit          s_open;

    always #2 clk = ~clk;

    assign chk_ok = ({1'b0, chk_addr} < perm_hi);

    page_commit_buffer u_page_commit_buffer (
        .clk(clk), .rst(rst),
        .start_i(start), .start_addr_i(start_addr),
        .load_i(load), .load_data_i(load_data),
        .desel_i(desel), .desel_whole_i(whole),
        .chk_addr_o(chk_addr), .chk_ok_i(chk_ok),
        .busy_o(busy), .done_o(done),
        .rd_req_i(rd_req), .rd_addr_i(rd_addr),
        .rd_data_o(rd_data), .rd_valid_o(rd_valid), .rd_refused_o(rd_refused)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic m_start(input logic [9:0] a);
        s_open = 1; s_mask = '0; s_base = a[9:4]; s_ptr = a[3:0];
    endtask

    task automatic m_load(input logic [7:0] d);
        if (s_open) begin
            s_buf[s_ptr] = d; s_mask[s_ptr] = 1'b1; s_ptr = s_ptr + 1'b1;
        end
    endtask

    function automatic bit m_desel(input bit w);
        bit go;
        go = s_open && w && (s_mask != 0);
        if (go) begin
            for (int p = 0; p < 16; p++) begin
                logic [9:0] a;
                a = {s_base, 4'(p)};
                if (s_mask[p] && ({1'b0, a} < perm_hi)) ref_mem[a] = s_buf[p];
            end
        end
        s_open = 0;
        return go;
    endfunction

    task automatic t_start(input logic [9:0] a);
        @(negedge clk); start = 1; start_addr = a;
        @(negedge clk); start = 0;
        m_start(a);
    endtask

    task automatic t_load(input logic [7:0] d);
        @(negedge clk); load = 1; load_data = d;
        @(negedge clk); load = 0;
        m_load(d);
    endtask

    // call at the negedge right after the deselect edge
    task automatic t_prog(input bit exp_go, input string tag);
        int n, dones, done_at;
        if (!exp_go) begin
            repeat (3) begin
                chk(busy == 0, {tag, " no programming"}, busy, 0);
                @(negedge clk);
            end
            return;
        end
        n = 0; dones = 0; done_at = -1;
        while (busy && n < PROG + 5) begin
            n++;
            if (done) begin dones++; done_at = n; end
            @(negedge clk);
        end
        chk(n == PROG, {tag, " R2 busy length"}, n, PROG);
        chk(dones == 1 && done_at == PROG, {tag, " R9 done pulse"}, done_at, PROG);
    endtask

    task automatic t_desel(input bit w, input string tag);
        bit go;
        @(negedge clk); desel = 1; whole = w;
        @(negedge clk); desel = 0; whole = 0;
        go = m_desel(w);
        t_prog(go, tag);
    endtask

    task automatic t_read(input logic [9:0] a, input string tag);
        @(negedge clk); rd_req = 1; rd_addr = a;
        @(negedge clk);
        chk(rd_valid && !rd_refused && rd_data == ref_mem[a], {tag, " R8 read"},
            rd_data, ref_mem[a]);
        rd_req = 0;
    endtask

    initial begin : main
        int n, done_at;
        bit go;
        void'($urandom(32'd7741));
        for (int i = 0; i < 1024; i++) ref_mem[i] = 8'h00;
        s_open = 0; s_mask = '0;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        chk(!busy && !done && !rd_valid && !rd_refused, "R1 reset outputs",
            {busy, done, rd_valid, rd_refused}, 0);
        t_read(10'h000, "R1 reset array");
        t_read(10'h3FF, "R1 reset array");

        // R2, R4: single byte
        t_start(10'h123); t_load(8'hA5); t_desel(1, "R2 single");
        t_read(10'h123, "R2 byte"); t_read(10'h124, "R4 untouched");

        // R3: wrap inside page
        t_start(10'h05E);
        for (int i = 0; i < 4; i++) t_load(8'h10 + 8'(i));
        t_desel(1, "R3 wrap");
        t_read(10'h050, "R3 wrapped pos0"); t_read(10'h051, "R3 wrapped pos1");
        t_read(10'h05F, "R3 pos15"); t_read(10'h060, "R3 next page untouched");
        t_start(10'h0A0);
        for (int i = 0; i < 18; i++) t_load(8'h40 + 8'(i));
        t_desel(1, "R3 overwrite");
        t_read(10'h0A0, "R3 overwritten pos0"); t_read(10'h0A2, "R3 pos2");

        // R5, R6: discards
        t_start(10'h200); t_load(8'h77); t_load(8'h78); t_desel(0, "R5 partial byte");
        t_read(10'h200, "R5 unchanged");
        t_start(10'h210); t_desel(1, "R6 no data");

        // R7: permit
        perm_hi = 11'h308;
        t_start(10'h300);
        for (int i = 0; i < 16; i++) t_load(8'hC0 + 8'(i));
        t_desel(1, "R7 permit");
        t_read(10'h307, "R7 permitted"); t_read(10'h308, "R7 blocked");
        perm_hi = 11'h400;

        // R11: load and deselect together
        t_start(10'h2C4);
        @(negedge clk); load = 1; load_data = 8'h5A; desel = 1; whole = 1;
        @(negedge clk); load = 0; desel = 0; whole = 0;
        m_load(8'h5A); go = m_desel(1);
        chk(go && busy, "R11 same-cycle commit", busy, 1);
        t_prog(go, "R11");
        t_read(10'h2C4, "R11 byte");

        // R8, R10: traffic during the window; read in the done cycle
        t_start(10'h150); t_load(8'h3C);
        @(negedge clk); desel = 1; whole = 1;
        @(negedge clk); desel = 0; whole = 0;
        go = m_desel(1);
        n = 0; done_at = -1;
        while (busy && n < PROG + 5) begin
            n++;
            start = 0; load = 0; desel = 0; whole = 0;
            if (n == 3) begin start = 1; start_addr = 10'h160; end
            else if (n == 4) begin load = 1; load_data = 8'hEE; end
            else if (n == 5) begin desel = 1; whole = 1; end
            else if (n == 6) begin rd_req = 1; rd_addr = 10'h150; end
            else if (n == 7) begin
                chk(rd_refused && !rd_valid, "R8 refused while busy", rd_refused, 1);
                rd_req = 0;
            end
            if (done) begin done_at = n; rd_req = 1; rd_addr = 10'h150; end
            @(negedge clk);
        end
        chk(n == PROG, "R10 window length kept", n, PROG);
        chk(done_at == PROG, "R9 done in last cycle", done_at, PROG);
        chk(rd_refused && !rd_valid, "R8 refused in done cycle", rd_refused, 1);
        @(negedge clk);
        chk(rd_valid && rd_data == 8'h3C, "R8 served after window", rd_data, 8'h3C);
        rd_req = 0;
        repeat (3) begin
            chk(!busy, "R10 ignored deselect", busy, 0);
            @(negedge clk);
        end
        t_read(10'h160, "R10 ignored load");

        // random sessions
        for (int s = 0; s < 30; s++) begin
            logic [9:0] a;
            int cnt;
            bit w;
            a = 10'($urandom % 1024);
            cnt = int'($urandom % 21);
            w = ($urandom % 4) != 0;
            case ($urandom % 4)
                0: perm_hi = 11'h400;
                1: perm_hi = 11'h300;
                2: perm_hi = 11'h200;
                default: perm_hi = 11'h400;
            endcase
            t_start(a);
            for (int i = 0; i < cnt; i++) t_load(8'($urandom));
            t_desel(w, "R3 R7 random");
            for (int p = 0; p < 16; p++) t_read({a[9:4], 4'(p)}, "R4 random page");
        end

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        fails++;
        total++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule